// File: doc/BRIEF.md
# PHY Test-Port Register Programmer

This block programs the internal configuration registers of a physical-layer macro through its narrow test port. That port has four parts: a clear line, a strobe clock, a select line that marks address versus data, and an 8-bit data bus. A controller starts the block with a start command. The block then holds the PHY in reset and pulses the test clear line. After that it accepts (address, value) pairs over a valid/ready handshake. Each pair becomes two strobed phases on the port. In the first the select line is high and the bus carries the address. In the second the select line is low and the bus carries the value.

The controller issues the clock-lane timing writes first, then the data-lane writes for each active lane, then the PLL writes. It then requests power-up. The block raises the PHY clock enable, the shutdown release and the reset release in three steps, with a fixed gap between steps. It then samples a status word at regular intervals. A set lock bit or a set clock-lane stop-state bit counts as success. If a bounded number of samples passes without either bit, the block raises a timeout flag. The completion flag and the timeout flag stay set until the next start command.

Top module: `ptp_prog`

## Requirements
- R1: After reset, every test-port output and PHY control output is low, and `req_ready_o`, `done_o` and `timeout_o` are low.
- R2: The phase length N is `half_i`, and a value of 0 counts as 1. After a start command, `tst_clr_o` is high for N cycles and then low for N cycles, and `req_ready_o` then goes high. The clock enable, shutdown release and reset release stay low throughout.
- R3: An accepted request first drives an address phase. In this phase `tst_en_o` is 1 and `tst_din_o` equals the address. `tst_clk_o` is high for N cycles and then low for N cycles.
- R4: The data phase follows. In this phase `tst_en_o` is 0 and `tst_din_o` equals the value. `tst_clk_o` is again high for N cycles and then low for N cycles.
- R5: `req_ready_o` drops on the cycle after a request is accepted and stays low for exactly 4N cycles. Each accepted request produces exactly two test-clock pulses.
- R6: The block samples `half_i` when it accepts a start or a request. If the sampled value is 0, every phase lasts one cycle.
- R7: Before the first start command, requests and power-up commands have no effect. `req_ready_o` stays low, no test-clock pulse appears and the PHY controls stay low.
- R8: Power-up raises `phy_clken_o` first. `phy_shutdn_n_o` rises STEP_CYC cycles later, and `phy_rst_n_o` rises STEP_CYC cycles after that.
- R9: Status is sampled every POLL_GAP cycles, starting STEP_CYC cycles after the reset release. If the lock bit (bit 0) is set when a sample is taken, `done_o` rises with `timeout_o` low.
- R10: If POLL_MAX samples all show neither bit set, `done_o` and `timeout_o` both rise. This happens STEP_CYC + POLL_MAX·POLL_GAP cycles after `phy_rst_n_o` rises.
- R11: `done_o` and `timeout_o` hold their values until the next start command. That command clears both flags and drives the PHY controls low again.
- R12: The stop-state bit (bit 2) alone also counts as success. With it set, `done_o` rises STEP_CYC + POLL_GAP cycles after the reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a programming session (accepted when idle-off or finished) |
| half_i | input | HALF_W | Test-clock phase length in cycles (0 acts as 1) |
| req_valid_i | input | 1 | Register write request valid |
| req_addr_i | input | DW | PHY register address |
| req_data_i | input | DW | PHY register value |
| req_ready_o | output | 1 | Block can accept a write request |
| pwr_go_i | input | 1 | Begin staged power-up and status polling |
| stat_i | input | STAT_W | PHY status word (lock and stop-state bits) |
| tst_clr_o | output | 1 | Test-port clear |
| tst_clk_o | output | 1 | Test-port strobe clock |
| tst_en_o | output | 1 | Test-port select: 1 address, 0 data |
| tst_din_o | output | DW | Test-port data bus |
| phy_clken_o | output | 1 | PHY clock enable |
| phy_shutdn_n_o | output | 1 | PHY shutdown release (active low shutdown) |
| phy_rst_n_o | output | 1 | PHY reset release (active low reset) |
| done_o | output | 1 | Power-up polling finished |
| timeout_o | output | 1 | Polling ended without lock or stop state |

## Verification
The hardest case to reach from the ports is a lock that appears only after several samples have already failed. The status input passes through a synchronizer and is only examined at the end of each polling interval. The bench therefore counts cycles from the rising edge of the reset release and raises the lock bit a few cycles after the third sample point. It then expects completion at exactly the fourth sample. A second pass holds the status at zero for the full timeout and checks the exact cycle on which the flags rise. A third pass sets only the stop-state bit.

// File: rtl/ptp_pkg.sv
package ptp_pkg;

   typedef enum logic [3:0] {
      ST_OFF,
      ST_CLR_HI,
      ST_CLR_LO,
      ST_IDLE,
      ST_A_HI,
      ST_A_LO,
      ST_D_HI,
      ST_D_LO,
      ST_PW_CK,
      ST_PW_SD,
      ST_PW_RS,
      ST_POLL,
      ST_FIN
   } ptp_state_t;

   function automatic int ptp_max3(input int a, input int b, input int c);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

   function automatic int ptp_bits(input int v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/ptp_timer.sv
module ptp_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         expire_o
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load_i)
         cnt <= val_i;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expire_o = (cnt == '0);

   // R2: a running phase shortens by exactly one cycle per clock
   p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/ptp_poller.sv
module ptp_poller #(
   parameter int STAT_W      = 8,
   parameter int LOCK_BIT    = 0,
   parameter int STOP_BIT    = 2,
   parameter int SYNC_STAGES = 2,
   parameter int POLL_MAX    = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] stat_i,
   input  logic              clr_i,
   input  logic              step_i,
   output logic              hit_o,
   output logic              last_o
);

   localparam int ATT_W = ptp_pkg::ptp_bits(POLL_MAX);
   localparam logic [STAT_W-1:0] HIT_MASK =
      (STAT_W'(1) << LOCK_BIT) | (STAT_W'(1) << STOP_BIT);
   localparam logic [ATT_W-1:0] ATT_LAST = ATT_W'(POLL_MAX - 1);

   logic [STAT_W-1:0] stat_s;
   logic [ATT_W-1:0]  att;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign stat_s = stat_i;
      end else begin : g_sync
         logic [STAT_W-1:0] chain [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '0;
            end else begin
               chain[0] <= stat_i;
               for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign stat_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         att <= '0;
      else if (clr_i)
         att <= '0;
      else if (step_i)
         att <= att + 1'b1;
   end

   assign hit_o  = |(stat_s & HIT_MASK);
   assign last_o = (att == ATT_LAST);

   // R10: the sample count never runs past the limit
   p_attempt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      att <= ATT_LAST);

   // R10: no further step is requested once the last sample is reached
   p_no_step_past_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> !step_i);

endmodule

// File: rtl/ptp_prog.sv
module ptp_prog #(
   parameter int DW          = 8,
   parameter int HALF_W      = 4,
   parameter int STEP_CYC    = 8,
   parameter int POLL_GAP    = 16,
   parameter int POLL_MAX    = 100,
   parameter int STAT_W      = 8,
   parameter int LOCK_BIT    = 0,
   parameter int STOP_BIT    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [HALF_W-1:0] half_i,
   input  logic              req_valid_i,
   input  logic [DW-1:0]     req_addr_i,
   input  logic [DW-1:0]     req_data_i,
   output logic              req_ready_o,
   input  logic              pwr_go_i,
   input  logic [STAT_W-1:0] stat_i,
   output logic              tst_clr_o,
   output logic              tst_clk_o,
   output logic              tst_en_o,
   output logic [DW-1:0]     tst_din_o,
   output logic              phy_clken_o,
   output logic              phy_shutdn_n_o,
   output logic              phy_rst_n_o,
   output logic              done_o,
   output logic              timeout_o
);
   import ptp_pkg::*;

   localparam int TMR_W = ptp_max3(HALF_W, ptp_bits(STEP_CYC), ptp_bits(POLL_GAP));
   localparam logic [TMR_W-1:0] STEP_M1 = TMR_W'(STEP_CYC - 1);
   localparam logic [TMR_W-1:0] GAP_M1  = TMR_W'(POLL_GAP - 1);

   generate
      if (DW < 1)                          begin : g_bad_dw   $error("DW must be at least 1");           end
      if (HALF_W < 1)                      begin : g_bad_hw   $error("HALF_W must be at least 1");       end
      if (STEP_CYC < 1)                    begin : g_bad_st   $error("STEP_CYC must be at least 1");     end
      if (POLL_GAP < 1)                    begin : g_bad_gap  $error("POLL_GAP must be at least 1");     end
      if (POLL_MAX < 1)                    begin : g_bad_max  $error("POLL_MAX must be at least 1");     end
      if (LOCK_BIT >= STAT_W || STOP_BIT >= STAT_W)
                                           begin : g_bad_bit  $error("status bit outside status word");  end
      if (SYNC_STAGES < 0)                 begin : g_bad_sync $error("SYNC_STAGES cannot be negative");  end
   endgenerate

   ptp_state_t        st, nxt;
   logic [HALF_W-1:0] half_q;
   logic [DW-1:0]     addr_q, data_q;
   logic              done_q, to_q;

   logic              tmr_ld, tmr_exp;
   logic [TMR_W-1:0]  tmr_val;
   logic              accept, take_start;
   logic              poll_clr, poll_step, poll_hit, poll_last;
   logic              set_done, set_to;
   logic [TMR_W-1:0]  n_live_m1, n_q_m1;

   assign n_live_m1 = (half_i == '0) ? '0 : TMR_W'(half_i - 1'b1);
   assign n_q_m1    = (half_q == '0) ? '0 : TMR_W'(half_q - 1'b1);

   ptp_timer #(.W(TMR_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (tmr_ld),
      .val_i    (tmr_val),
      .expire_o (tmr_exp)
   );

   ptp_poller #(
      .STAT_W      (STAT_W),
      .LOCK_BIT    (LOCK_BIT),
      .STOP_BIT    (STOP_BIT),
      .SYNC_STAGES (SYNC_STAGES),
      .POLL_MAX    (POLL_MAX)
   ) u_poll (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_i (stat_i),
      .clr_i  (poll_clr),
      .step_i (poll_step),
      .hit_o  (poll_hit),
      .last_o (poll_last)
   );

   always_comb begin
      nxt        = st;
      tmr_ld     = 1'b0;
      tmr_val    = '0;
      accept     = 1'b0;
      take_start = 1'b0;
      poll_clr   = 1'b0;
      poll_step  = 1'b0;
      set_done   = 1'b0;
      set_to     = 1'b0;
      unique case (st)
         ST_OFF, ST_FIN: begin
            if (start_i) begin
               take_start = 1'b1;
               nxt        = ST_CLR_HI;
               tmr_ld     = 1'b1;
               tmr_val    = n_live_m1;
            end
         end
         ST_CLR_HI: if (tmr_exp) begin nxt = ST_CLR_LO; tmr_ld = 1'b1; tmr_val = n_q_m1; end
         ST_CLR_LO: if (tmr_exp) nxt = ST_IDLE;
         ST_IDLE: begin
            if (req_valid_i) begin
               accept  = 1'b1;
               nxt     = ST_A_HI;
               tmr_ld  = 1'b1;
               tmr_val = n_live_m1;
            end else if (pwr_go_i) begin
               nxt     = ST_PW_CK;
               tmr_ld  = 1'b1;
               tmr_val = STEP_M1;
            end
         end
         ST_A_HI: if (tmr_exp) begin nxt = ST_A_LO; tmr_ld = 1'b1; tmr_val = n_q_m1; end
         ST_A_LO: if (tmr_exp) begin nxt = ST_D_HI; tmr_ld = 1'b1; tmr_val = n_q_m1; end
         ST_D_HI: if (tmr_exp) begin nxt = ST_D_LO; tmr_ld = 1'b1; tmr_val = n_q_m1; end
         ST_D_LO: if (tmr_exp) nxt = ST_IDLE;
         ST_PW_CK: if (tmr_exp) begin nxt = ST_PW_SD; tmr_ld = 1'b1; tmr_val = STEP_M1; end
         ST_PW_SD: if (tmr_exp) begin nxt = ST_PW_RS; tmr_ld = 1'b1; tmr_val = STEP_M1; end
         ST_PW_RS: begin
            if (tmr_exp) begin
               nxt      = ST_POLL;
               tmr_ld   = 1'b1;
               tmr_val  = GAP_M1;
               poll_clr = 1'b1;
            end
         end
         ST_POLL: begin
            if (tmr_exp) begin
               if (poll_hit) begin
                  nxt      = ST_FIN;
                  set_done = 1'b1;
               end else if (poll_last) begin
                  nxt      = ST_FIN;
                  set_done = 1'b1;
                  set_to   = 1'b1;
               end else begin
                  poll_step = 1'b1;
                  tmr_ld    = 1'b1;
                  tmr_val   = GAP_M1;
               end
            end
         end
         default: nxt = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_OFF;
         half_q <= '0;
         addr_q <= '0;
         data_q <= '0;
         done_q <= 1'b0;
         to_q   <= 1'b0;
      end else begin
         st <= nxt;
         if (take_start || accept) half_q <= half_i;
         if (accept) begin
            addr_q <= req_addr_i;
            data_q <= req_data_i;
         end
         if (take_start) begin
            done_q <= 1'b0;
            to_q   <= 1'b0;
         end else begin
            if (set_done) done_q <= 1'b1;
            if (set_to)   to_q   <= 1'b1;
         end
      end
   end

   assign req_ready_o    = (st == ST_IDLE);
   assign tst_clr_o      = (st == ST_CLR_HI);
   assign tst_clk_o      = (st == ST_A_HI) || (st == ST_D_HI);
   assign tst_en_o       = (st == ST_A_HI) || (st == ST_A_LO);
   assign tst_din_o      = tst_en_o ? addr_q :
                           ((st == ST_D_HI) || (st == ST_D_LO)) ? data_q : '0;
   assign phy_clken_o    = (st == ST_PW_CK) || (st == ST_PW_SD) || (st == ST_PW_RS) ||
                           (st == ST_POLL)  || (st == ST_FIN);
   assign phy_shutdn_n_o = (st == ST_PW_SD) || (st == ST_PW_RS) || (st == ST_POLL) ||
                           (st == ST_FIN);
   assign phy_rst_n_o    = (st == ST_PW_RS) || (st == ST_POLL) || (st == ST_FIN);
   assign done_o         = done_q;
   assign timeout_o      = to_q;

   // R2: test clear only while the PHY is fully held off
   p_clr_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tst_clr_o |-> (!phy_clken_o && !phy_shutdn_n_o && !phy_rst_n_o));

   // R3: bus value is steady while the strobe is high
   p_din_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tst_clk_o && $past(tst_clk_o)) |-> $stable(tst_din_o));

   // R5: no new request can be taken while a strobe is in flight
   p_ready_vs_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tst_clk_o |-> !req_ready_o);

   // R8: shutdown release only after the clock enable was already up
   p_stage_sd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_shutdn_n_o) |-> (phy_clken_o && $past(phy_clken_o)));

   // R8: reset release only after shutdown release was already up
   p_stage_rs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_rst_n_o) |-> $past(phy_shutdn_n_o));

   // R10: a timeout always comes with completion
   p_to_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> done_o);

   // R11: completion holds until a start command
   p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> done_o);

endmodule

// File: tb/ptp_prog_tb.sv
`timescale 1ns/1ps
module ptp_prog_tb;

   localparam int DW       = 8;
   localparam int HALF_W   = 4;
   localparam int STEP_CYC = 8;
   localparam int POLL_GAP = 16;
   localparam int POLL_MAX = 100;
   localparam int STAT_W   = 8;

   // {address, value, half}
   localparam logic [19:0] VEC [6] = '{
      {8'h00, 8'hFF, 4'd1},
      {8'hFF, 8'h00, 4'd2},
      {8'h5A, 8'hC3, 4'd0},
      {8'h12, 8'h34, 4'd3},
      {8'h81, 8'h7E, 4'd5},
      {8'hE0, 8'h0F, 4'd1}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [HALF_W-1:0] half_i = '0;
   logic              req_valid_i = 1'b0;
   logic [DW-1:0]     req_addr_i = '0;
   logic [DW-1:0]     req_data_i = '0;
   logic              req_ready_o;
   logic              pwr_go_i = 1'b0;
   logic [STAT_W-1:0] stat_i = '0;
   logic              tst_clr_o, tst_clk_o, tst_en_o;
   logic [DW-1:0]     tst_din_o;
   logic              phy_clken_o, phy_shutdn_n_o, phy_rst_n_o;
   logic              done_o, timeout_o;

   int tests = 0;
   int fails = 0;

   int       ncap = 0;
   logic     cap_en  [64];
   logic [7:0] cap_din [64];
   int       cap_w   [64];
   int       hi_len = 0;
   logic     clk_prev = 1'b0;

   always #2 clk = ~clk;

   ptp_prog #(
      .DW(DW), .HALF_W(HALF_W), .STEP_CYC(STEP_CYC), .POLL_GAP(POLL_GAP),
      .POLL_MAX(POLL_MAX), .STAT_W(STAT_W), .LOCK_BIT(0), .STOP_BIT(2), .SYNC_STAGES(2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_i(half_i),
      .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .req_data_i(req_data_i),
      .req_ready_o(req_ready_o), .pwr_go_i(pwr_go_i), .stat_i(stat_i),
      .tst_clr_o(tst_clr_o), .tst_clk_o(tst_clk_o), .tst_en_o(tst_en_o),
      .tst_din_o(tst_din_o), .phy_clken_o(phy_clken_o),
      .phy_shutdn_n_o(phy_shutdn_n_o), .phy_rst_n_o(phy_rst_n_o),
      .done_o(done_o), .timeout_o(timeout_o)
   );

   // strobe monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (tst_clk_o && !clk_prev) begin
         if (ncap < 64) begin
            cap_en[ncap]  = tst_en_o;
            cap_din[ncap] = tst_din_o;
         end
         hi_len = 1;
      end else if (tst_clk_o) begin
         hi_len = hi_len + 1;
      end else if (clk_prev) begin
         if (ncap < 64) cap_w[ncap] = hi_len;
         ncap = ncap + 1;
      end
      clk_prev = tst_clk_o;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_ready();
      for (int k = 0; k < 500 && !req_ready_o; k++) @(negedge clk);
   endtask

   task automatic do_start(input logic [HALF_W-1:0] h);
      half_i  = h;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] d,
                           input logic [HALF_W-1:0] h);
      int base, n, low;
      n = (h == 0) ? 1 : int'(h);
      wait_ready();
      base        = ncap;
      half_i      = h;
      req_addr_i  = a;
      req_data_i  = d;
      req_valid_i = 1'b1;
      @(negedge clk);
      req_valid_i = 1'b0;
      low = 0;
      for (int k = 0; k < 500 && !req_ready_o; k++) begin
         low++;
         @(negedge clk);
      end
      check(low == 4 * n, "R5 ready low span", low, 4 * n);
      check(ncap == base + 2, "R5 two strobes per request", ncap - base, 2);
      check(cap_en[base] == 1'b1 && cap_din[base] == a, "R3 address phase bus",
            int'(cap_din[base]), int'(a));
      check(cap_w[base] == n, "R3 address strobe width (R6 when half is 0)", cap_w[base], n);
      check(cap_en[base+1] == 1'b0 && cap_din[base+1] == d, "R4 data phase bus",
            int'(cap_din[base+1]), int'(d));
      check(cap_w[base+1] == n, "R4 data strobe width (R6 when half is 0)", cap_w[base+1], n);
   endtask

   task automatic pulse_pwr();
      wait_ready();
      pwr_go_i = 1'b1;
      @(negedge clk);
      pwr_go_i = 1'b0;
   endtask

   // counts samples with reset released and done low
   task automatic count_to_done(output int cnt, input int lock_at);
      cnt = 0;
      for (int k = 0; k < 500 && !phy_rst_n_o; k++) @(negedge clk);
      for (int k = 0; k < 5000 && !done_o; k++) begin
         cnt++;
         if (lock_at > 0 && cnt == lock_at) stat_i = 8'h01;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int cnt, w;
      repeat (3) @(negedge clk);
      check({tst_clr_o, tst_clk_o, tst_en_o, tst_din_o, phy_clken_o, phy_shutdn_n_o,
             phy_rst_n_o, req_ready_o, done_o, timeout_o} == '0,
            "R1 outputs under reset", int'(tst_din_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!req_ready_o && !done_o && !timeout_o && !phy_clken_o, "R1 state after reset",
            int'(req_ready_o), 0);

      // R7: commands before the first start are ignored
      req_valid_i = 1'b1;
      pwr_go_i    = 1'b1;
      cnt = 0;
      for (int k = 0; k < 20; k++) begin
         if (req_ready_o || phy_clken_o || tst_clk_o) cnt++;
         @(negedge clk);
      end
      req_valid_i = 1'b0;
      pwr_go_i    = 1'b0;
      check(cnt == 0, "R7 activity before start", cnt, 0);
      check(ncap == 0, "R7 strobes before start", ncap, 0);

      // R2: clear pulse with N = 3
      do_start(4'd3);
      w = 0;
      for (int k = 0; k < 100 && tst_clr_o; k++) begin
         if (phy_clken_o || phy_shutdn_n_o || phy_rst_n_o) w = w + 1000;
         w++;
         @(negedge clk);
      end
      check(w == 3, "R2 clear width with PHY held", w, 3);
      cnt = 0;
      for (int k = 0; k < 100 && !req_ready_o; k++) begin
         cnt++;
         @(negedge clk);
      end
      check(cnt == 3, "R2 clear low time before ready", cnt, 3);

      // vector walk: R3 R4 R5 R6
      for (int i = 0; i < 6; i++) begin
         do_write(VEC[i][19:12], VEC[i][11:4], VEC[i][3:0]);
      end

      // R8 and R12: stop-state alone, staged power-up
      stat_i = 8'h04;
      pulse_pwr();
      for (int k = 0; k < 100 && !phy_clken_o; k++) @(negedge clk);
      cnt = 0;
      for (int k = 0; k < 100 && !phy_shutdn_n_o; k++) begin
         cnt++;
         @(negedge clk);
      end
      check(cnt == STEP_CYC, "R8 clock enable to shutdown release", cnt, STEP_CYC);
      cnt = 0;
      for (int k = 0; k < 100 && !phy_rst_n_o; k++) begin
         if (phy_shutdn_n_o) cnt++;
         @(negedge clk);
      end
      check(cnt == STEP_CYC, "R8 shutdown release to reset release", cnt, STEP_CYC);
      count_to_done(cnt, 0);
      check(cnt == STEP_CYC + POLL_GAP, "R12 stop-state success time", cnt, STEP_CYC + POLL_GAP);
      check(!timeout_o, "R12 no timeout on stop state", int'(timeout_o), 0);

      // R11: flags hold
      stat_i = 8'h00;
      repeat (40) @(negedge clk);
      check(done_o && !timeout_o && phy_rst_n_o, "R11 flags held", int'(done_o), 1);

      // R11: start clears, R10 timeout
      do_start(4'd1);
      check(!done_o && !timeout_o && !phy_rst_n_o && !phy_clken_o && tst_clr_o,
            "R11 start clears flags and PHY", int'(done_o), 0);
      do_write(8'h33, 8'h44, 4'd1);
      pulse_pwr();
      count_to_done(cnt, 0);
      check(cnt == STEP_CYC + POLL_MAX * POLL_GAP, "R10 timeout time", cnt,
            STEP_CYC + POLL_MAX * POLL_GAP);
      check(timeout_o && done_o, "R10 timeout flags", int'(timeout_o), 1);

      // R9: lock appears after three failed samples
      do_start(4'd2);
      wait_ready();
      pulse_pwr();
      count_to_done(cnt, STEP_CYC + 3 * POLL_GAP + 2);
      check(cnt == STEP_CYC + 4 * POLL_GAP, "R9 late lock success time", cnt,
            STEP_CYC + 4 * POLL_GAP);
      check(done_o && !timeout_o, "R9 lock flags", int'(timeout_o), 0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule